// File: doc/BRIEF.md
# Programmable CRC Accelerator

This block is a register-mapped checksum engine. Software sets a generator polynomial and a control word, then writes 32-bit data words. Each write folds the whole word into a running 16-bit or 32-bit remainder within one clock. The written word can be bit- and byte-reordered on the way in. The remainder can be reordered and inverted on the way out.

A control flag turns data-register writes into seed loads, so software can set a starting value before it streams a message. Reads come from a registered read port, which returns the value one cycle after the request.

Top module: `crc_accel`

## Requirements
- R1: After reset the accumulator holds 0xFFFFFFFF, the polynomial register holds 0x00001021 and the control register holds 0. Because control is 0, the first data read returns 0x0000FFFF.
- R2: Register offsets are fixed:
  - 0x0 is the data register.
  - 0x4 is the polynomial register, read back as all 32 bits.
  - 0x8 is the control register.

  A read pulse loads rdata at the next rising edge. rdata holds its value while no read is requested.
- R3: Control fields:
  - Bit 24 selects the width: 1 gives a 32-bit CRC, 0 gives a 16-bit CRC.
  - Bit 25 selects seed mode.
  - Bit 26 selects complemented reads.
  - Bits 29:28 select the read transpose.
  - Bits 31:30 select the write transpose.

  All other control bits read as zero.
- R4: In 32-bit mode a data write runs 32 steps, taking the transposed word from bit 31 down to bit 0. Each step computes f = acc[31] xor d, shifts acc left by one, and xors in the full polynomial when f is 1.
- R5: In 16-bit mode each step uses acc[15] and polynomial bits 15:0 on the low half-word. Every accumulator update clears the upper half-word, and reads see the upper half-word as zero before transpose and complement.
- R6: With seed mode set, a data write loads the transposed word into the accumulator, keeping only bits 15:0 in 16-bit mode, and no CRC step happens.
- R7: The write transpose codes are:
  - 0 passes the word unchanged.
  - 1 reverses the bits inside each byte.
  - 2 reverses all 32 bits.
  - 3 reverses the byte order.
- R8: The read transpose uses the same four codes as R7, applied to the result view.
- R9: When the complement bit is set, data reads return the bitwise inverse of the transposed result.
- R10: A data read issued in the cycle directly after a data write returns the updated result.
- R11: Offsets other than 0x0, 0x4 and 0x8 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read request for one cycle |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach is an accumulator that mixes state from different control settings. An example is a 16-bit remainder carried into 32-bit mode, or a seed loaded under one write transpose and then read through another read transpose with the complement set. The stimulus reaches these states by rewriting the control word at random between data writes and seed loads. Each data read is checked against a reference model that tracks the accumulator across those changes. Directed cases pin each transpose code alone on known patterns.

// File: rtl/crc_accel_pkg.sv
package crc_accel_pkg;
  localparam int DW = 32;
  localparam int HW = DW / 2;
  localparam int NB = DW / 8;

  localparam int OFS_DATA = 'h0;
  localparam int OFS_POLY = 'h4;
  localparam int OFS_CTRL = 'h8;

  localparam int BIT_W32  = 24;
  localparam int BIT_SEED = 25;
  localparam int BIT_CPL  = 26;
  localparam int BIT_RTR  = 28;
  localparam int BIT_WTR  = 30;

  localparam logic [DW-1:0] ACC_RST  = '1;
  localparam logic [DW-1:0] POLY_RST = 32'h0000_1021;

  typedef enum logic [1:0] {
    TR_NONE  = 2'd0,
    TR_BITS  = 2'd1,
    TR_BOTH  = 2'd2,
    TR_BYTES = 2'd3
  } tr_mode_e;

  typedef struct packed {
    tr_mode_e wr_tr;
    tr_mode_e rd_tr;
    logic     cpl;
    logic     seed;
    logic     w32;
  } ctrl_t;
endpackage

// File: rtl/crc_transpose.sv
module crc_transpose
  import crc_accel_pkg::*;
#(
  parameter int W = DW
) (
  input  tr_mode_e       mode,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout
);
  localparam int LANES = W / 8;

  logic [W-1:0] bitrev;
  logic [W-1:0] byterev;
  logic [W-1:0] fullrev;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign bitrev[b*8+k] = din[b*8+7-k];
    end
    assign byterev[b*8 +: 8] = din[(LANES-1-b)*8 +: 8];
    assign fullrev[b*8 +: 8] = bitrev[(LANES-1-b)*8 +: 8];
  end

  always_comb begin
    unique case (mode)
      TR_BITS:  dout = bitrev;
      TR_BOTH:  dout = fullrev;
      TR_BYTES: dout = byterev;
      default:  dout = din;
    endcase
  end

  always_comb begin
    if (!$isunknown({mode, din})) begin
      // R7
      pop_keep_chk: assert ($countones(dout) == $countones(din));
    end
  end
endmodule

// File: rtl/crc_update.sv
module crc_update
  import crc_accel_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] poly,
  input  logic [W-1:0] data,
  input  logic         w32,
  output logic [W-1:0] nxt
);
  localparam int H = W / 2;

  always_comb begin
    logic [W-1:0] c;
    logic         fb;
    c  = acc;
    fb = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (w32) begin
        fb = c[W-1] ^ data[i];
        c  = {c[W-2:0], 1'b0} ^ (fb ? poly : '0);
      end else begin
        fb      = c[H-1] ^ data[i];
        c[H-1:0] = {c[H-2:0], 1'b0} ^ (fb ? poly[H-1:0] : '0);
      end
    end
    nxt = w32 ? c : {{H{1'b0}}, c[H-1:0]};
  end

  always_comb begin
    if (!$isunknown({acc, data, w32})) begin
      // R4
      zero_in_zero_out_chk: assert (!(acc == '0 && data == '0) || nxt == '0);
    end
  end
endmodule

// File: rtl/crc_accel.sv
module crc_accel
  import crc_accel_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(OFS_POLY);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  ctrl_t         ctrl_q;
  logic [DW-1:0] poly_q;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] wr_word;
  logic [DW-1:0] acc_upd;
  logic [DW-1:0] view;
  logic [DW-1:0] view_tr;
  logic [DW-1:0] data_rd;
  logic [DW-1:0] ctrl_rd;
  logic          mapped;

  crc_transpose #(.W(DW)) u_wr_tr (
    .mode (ctrl_q.wr_tr),
    .din  (wdata),
    .dout (wr_word)
  );

  crc_update #(.W(DW)) u_upd (
    .acc  (acc_q),
    .poly (poly_q),
    .data (wr_word),
    .w32  (ctrl_q.w32),
    .nxt  (acc_upd)
  );

  assign view = ctrl_q.w32 ? acc_q : {{HW{1'b0}}, acc_q[HW-1:0]};

  crc_transpose #(.W(DW)) u_rd_tr (
    .mode (ctrl_q.rd_tr),
    .din  (view),
    .dout (view_tr)
  );

  assign data_rd = ctrl_q.cpl ? ~view_tr : view_tr;

  always_comb begin
    ctrl_rd                      = '0;
    ctrl_rd[BIT_WTR +: 2]        = ctrl_q.wr_tr;
    ctrl_rd[BIT_RTR +: 2]        = ctrl_q.rd_tr;
    ctrl_rd[BIT_CPL]             = ctrl_q.cpl;
    ctrl_rd[BIT_SEED]            = ctrl_q.seed;
    ctrl_rd[BIT_W32]             = ctrl_q.w32;
  end

  assign mapped = (addr == A_DATA) || (addr == A_POLY) || (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= ACC_RST;
      poly_q <= POLY_RST;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (addr == A_DATA) begin
        if (ctrl_q.seed) begin
          acc_q <= ctrl_q.w32 ? wr_word : {{HW{1'b0}}, wr_word[HW-1:0]};
        end else begin
          acc_q <= acc_upd;
        end
      end else if (addr == A_POLY) begin
        poly_q <= wdata;
      end else if (addr == A_CTRL) begin
        ctrl_q.wr_tr <= tr_mode_e'(wdata[BIT_WTR +: 2]);
        ctrl_q.rd_tr <= tr_mode_e'(wdata[BIT_RTR +: 2]);
        ctrl_q.cpl   <= wdata[BIT_CPL];
        ctrl_q.seed  <= wdata[BIT_SEED];
        ctrl_q.w32   <= wdata[BIT_W32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == A_DATA)      rdata <= data_rd;
      else if (addr == A_POLY) rdata <= poly_q;
      else if (addr == A_CTRL) rdata <= ctrl_rd;
      else                     rdata <= '0;
    end
  end

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R3
  ctrl_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CTRL) |=> (rdata[27] == 1'b0 && rdata[23:0] == '0));

  // R5
  up_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_DATA && !ctrl_q.w32 && ctrl_q.rd_tr == TR_NONE && !ctrl_q.cpl)
    |=> rdata[DW-1:HW] == '0);

  // R6
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DATA && ctrl_q.seed && ctrl_q.w32 && ctrl_q.wr_tr == TR_NONE)
    |=> acc_q == $past(wdata));

  // R11
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> rdata == '0);
endmodule

// File: tb/sim_crc_accel.sv
module sim_crc_accel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic        rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_acc, m_poly, m_ctrl;

  localparam logic [31:0] CTRL_MASK = 32'hF700_0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_accel #(.ADDR_W(4)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [31:0] f_tr(input logic [31:0] x, input logic [1:0] m);
    logic [31:0] r;
    r = x;
    case (m)
      2'd1: for (int i = 0; i < 32; i++) r[(i/8)*8 + (7 - i%8)] = x[i];
      2'd2: for (int i = 0; i < 32; i++) r[31-i] = x[i];
      2'd3: r = {x[7:0], x[15:8], x[23:16], x[31:24]};
      default: r = x;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] f_crc(input logic [31:0] acc, input logic [31:0] poly,
                                        input logic [31:0] d, input logic w32);
    logic [31:0] a;
    logic [15:0] s;
    a = acc;
    s = acc[15:0];
    for (int i = 31; i >= 0; i--) begin
      if (w32) begin
        if (a[31] != d[i]) a = (a << 1) ^ poly;
        else               a = a << 1;
      end else begin
        if (s[15] != d[i]) s = (s << 1) ^ poly[15:0];
        else               s = s << 1;
      end
    end
    return w32 ? a : {16'h0, s};
  endfunction

  function automatic logic [31:0] f_view();
    logic [31:0] v;
    v = m_ctrl[24] ? m_acc : {16'h0, m_acc[15:0]};
    v = f_tr(v, m_ctrl[29:28]);
    return m_ctrl[26] ? ~v : v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] t;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    t = f_tr(d, m_ctrl[31:30]);
    case (a)
      4'h0: begin
        if (m_ctrl[25]) m_acc = m_ctrl[24] ? t : {16'h0, t[15:0]};
        else            m_acc = f_crc(m_acc, m_poly, t, m_ctrl[24]);
      end
      4'h4: m_poly = d;
      4'h8: m_ctrl = d & CTRL_MASK;
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] q);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    q = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, hold;
    logic [31:0] r0;
    r0 = $urandom(32'd20240611);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    m_acc = 32'hFFFF_FFFF; m_poly = 32'h0000_1021; m_ctrl = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    bus_rd(4'h0, q); check("R1 data", q, 32'h0000_FFFF);
    bus_rd(4'h4, q); check("R1 poly", q, 32'h0000_1021);
    bus_rd(4'h8, q); check("R1 ctrl", q, 32'h0);

    // R3 control fields and reserved bits
    bus_wr(4'h8, 32'hFFFF_FFFF);
    bus_rd(4'h8, q); check("R3 ctrl mask", q, 32'hF700_0000);
    bus_wr(4'h8, 32'h0000_0000);

    // R2 polynomial readback, hold without read
    bus_wr(4'h4, 32'h04C1_1DB7);
    bus_rd(4'h4, q); check("R2 poly", q, 32'h04C1_1DB7);
    hold = q;
    bus_wr(4'h4, 32'h1234_5678);
    repeat (2) @(negedge clk);
    check("R2 hold", rdata, hold);
    bus_wr(4'h4, 32'h04C1_1DB7);

    // R6 seed in 32-bit mode, then R4 update and R10 back-to-back read
    bus_wr(4'h8, 32'h0300_0000);
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, q); check("R6 seed32", q, 32'hFFFF_FFFF);
    bus_wr(4'h8, 32'h0100_0000);
    bus_wr(4'h0, 32'h3132_3334);
    bus_rd(4'h0, q); check("R4 R10 crc32", q, f_view());
    bus_wr(4'h0, 32'h0000_0000);
    bus_rd(4'h0, q); check("R4 crc32 zero word", q, f_view());

    // R5 16-bit mode, seed keeps low half
    bus_wr(4'h4, 32'hABCD_1021);
    bus_wr(4'h8, 32'h0200_0000);
    bus_wr(4'h0, 32'h5555_1D0F);
    bus_rd(4'h0, q); check("R5 R6 seed16", q, 32'h0000_1D0F);
    bus_wr(4'h8, 32'h0000_0000);
    bus_wr(4'h0, 32'hDEAD_BEEF);
    bus_rd(4'h0, q); check("R5 crc16", q, f_view());
    bus_wr(4'h8, 32'h0100_0000);
    bus_rd(4'h0, q); check("R5 upper cleared", q[31:16], 16'h0);

    // R7 each write transpose code on a seed load
    for (int m = 0; m < 4; m++) begin
      bus_wr(4'h8, (32'(m) << 30) | 32'h0300_0000);
      bus_wr(4'h0, 32'h0102_8040);
      bus_rd(4'h0, q); check($sformatf("R7 wr code %0d", m), q, f_view());
    end

    // R8 each read transpose code, R9 complement
    bus_wr(4'h8, 32'h0300_0000);
    bus_wr(4'h0, 32'h1122_4381);
    for (int m = 0; m < 4; m++) begin
      bus_wr(4'h8, (32'(m) << 28) | 32'h0100_0000);
      bus_rd(4'h0, q); check($sformatf("R8 rd code %0d", m), q, f_view());
      bus_wr(4'h8, (32'(m) << 28) | 32'h0500_0000);
      bus_rd(4'h0, q); check($sformatf("R9 cpl code %0d", m), q, f_view());
    end
    bus_wr(4'h8, 32'h2400_0000);
    bus_rd(4'h0, q); check("R9 R8 16-bit both", q, f_view());

    // R11 unmapped offset
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_rd(4'hC, q); check("R11 read zero", q, 32'h0);
    bus_rd(4'h4, q); check("R11 poly kept", q, m_poly);
    bus_rd(4'h8, q); check("R11 ctrl kept", q, m_ctrl);
    bus_rd(4'h0, q); check("R11 data kept", q, f_view());

    // Random mix: R4 R5 R6 R7 R8 R9
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0)      bus_wr(4'h8, $urandom());
      else if (op == 1) bus_wr(4'h4, $urandom());
      else if (op <= 6) bus_wr(4'h0, $urandom());
      else begin
        bus_rd(4'h0, q); check("R4 R5 R6 R7 R8 R9 random", q, f_view());
      end
    end
    bus_rd(4'h0, q); check("R10 final", q, f_view());

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule